// File: doc/BRIEF.md
# Key-Locked Paged Watchdog Configuration Port

This block sits behind a two-address I/O window: one address takes a register index, the other moves data to or from the indexed register. After reset the window is sealed. Software opens it by writing the opening key 0x87 to the index address on two consecutive index writes, and seals it again by writing 0xAA to the index address. While the window is open, a page-select register picks which logical page the data address reaches. Only one page is built here, the watchdog page (page 0x08). Other page numbers lead to empty space.

The watchdog page holds an enable bit, a choice of count unit (seconds or minutes), an 8-bit countdown that software loads and reads back, and two switches. These switches let keyboard or mouse activity reload the countdown from the last value software wrote. A prescaler derives seconds from the clock, and minutes from seconds. The countdown steps once per selected unit while the watchdog is enabled. When it runs out, the block raises a one-cycle reset pulse and switches itself off.

Top module: `lockcfg_wdog`

## Requirements
- R1: After reset the window is sealed, the reset output is low, and the enable bit, unit bit, countdown and reload switches of the watchdog page all read back 0.
- R2: The window opens only when two index-address writes in a row both carry 0x87. Any other index value in between restarts the key sequence. The writes that carry the key do not change the stored index. The index is kept across a seal and open cycle.
- R3: While sealed, data-address writes have no effect, and reads of either address return 0xFF.
- R4: An index-address write of 0xAA while open seals the window.
- R5: Index 0x07 holds the page number, which can be read back on any page. The watchdog registers are reached only when the page number is 0x08. On any other page those indexes read 0x00 and ignore writes.
- R6: Index 0x30 bit 0 is the watchdog enable (1 runs it). The other bits read 0.
- R7: Index 0xF5 bit 3 selects the count unit (0 seconds, 1 minutes). The other bits read 0.
- R8: A write to index 0xF6 loads the 8-bit countdown and its reload value and restarts the prescaler. A read returns the current countdown.
- R9: In seconds mode an enabled countdown steps down by one every TICKS_PER_SEC clocks, measured from the enabling write. A countdown of N expires TICKS_PER_SEC*N clocks after that write. Clearing the enable freezes the countdown.
- R10: In minutes mode each step takes SEC_PER_MIN*TICKS_PER_SEC clocks.
- R11: On expiry the reset output is high for exactly one clock. In the same cycle the countdown reads 0 and the enable bit is cleared.
- R12: Index 0xF7 bit 6 lets a keyboard pulse reload the countdown, and bit 7 does the same for a mouse pulse. With the bit at 0 that pulse leaves the countdown unchanged. The other bits of 0xF7 read 0.
- R13: Indexes not listed above read 0x00 on the watchdog page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the selected address |
| port_sel | input | 1 | 0 selects the index address, 1 the data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected address (combinational) |
| kbd_irq | input | 1 | Keyboard activity pulse |
| mouse_irq | input | 1 | Mouse activity pulse |
| wd_reset | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with TICKS_PER_SEC = 4 and SEC_PER_MIN = 3, so one second lasts 4 clocks and one minute lasts 12. With these values a full seconds-mode expiry and a full minutes-mode expiry each fit in a few dozen cycles, and the expiry times can be compared exactly against the clock counts. A minute step is long enough that register writes can land between steps without racing a tick. This makes it possible to freeze a partly consumed countdown and then try the keyboard and mouse reload paths on it.

// File: rtl/cfgwd_pkg.sv
package cfgwd_pkg;

    localparam logic [7:0] KEY_OPEN   = 8'h87;
    localparam logic [7:0] KEY_CLOSE  = 8'hAA;
    localparam logic [7:0] IDX_PAGE   = 8'h07;
    localparam logic [7:0] PAGE_WDOG  = 8'h08;
    localparam logic [7:0] IDX_ENABLE = 8'h30;
    localparam logic [7:0] IDX_UNIT   = 8'hF5;
    localparam logic [7:0] IDX_COUNT  = 8'hF6;
    localparam logic [7:0] IDX_SRC    = 8'hF7;

    localparam int BIT_ENABLE = 0;
    localparam int BIT_UNIT   = 3;
    localparam int BIT_KBD    = 6;
    localparam int BIT_MOUSE  = 7;

    typedef enum logic [1:0] {
        GATE_LOCKED = 2'd0,
        GATE_HALF   = 2'd1,
        GATE_OPEN   = 2'd2
    } gate_t;

    typedef struct packed {
        logic       wr;
        logic       is_data;
        logic [7:0] data;
    } bus_t;

    typedef struct packed {
        logic enable;
        logic minutes;
        logic kbd_reload;
        logic mouse_reload;
    } wdctl_t;

    function automatic logic [7:0] place_bit(input logic v, input int pos);
        logic [7:0] r;
        r = 8'h00;
        r[pos] = v;
        return r;
    endfunction

endpackage

// File: rtl/cfgwd_gate.sv
module cfgwd_gate
    import cfgwd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  bus_t bus_i,
    output logic open_o,
    output logic idx_wr_o
);
    gate_t state_q;
    logic  idx_access;

    assign idx_access = bus_i.wr && !bus_i.is_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GATE_LOCKED;
        end else if (idx_access) begin
            case (state_q)
                GATE_LOCKED: if (bus_i.data == KEY_OPEN) state_q <= GATE_HALF;
                GATE_HALF:   state_q <= (bus_i.data == KEY_OPEN) ? GATE_OPEN : GATE_LOCKED;
                GATE_OPEN:   if (bus_i.data == KEY_CLOSE) state_q <= GATE_LOCKED;
                default:     state_q <= GATE_LOCKED;
            endcase
        end
    end

    assign open_o   = (state_q == GATE_OPEN);
    assign idx_wr_o = open_o && idx_access && (bus_i.data != KEY_CLOSE);

    assert_open_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == GATE_OPEN && $past(state_q) != GATE_OPEN) |->
        ($past(state_q) == GATE_HALF && $past(bus_i.wr) && !$past(bus_i.is_data)
         && $past(bus_i.data) == KEY_OPEN));

    assert_close_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == GATE_OPEN && idx_access && bus_i.data == KEY_CLOSE) |=>
        state_q == GATE_LOCKED);

    assert_data_no_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_i.wr && bus_i.is_data) |=> $stable(state_q));

endmodule

// File: rtl/cfgwd_regs.sv
module cfgwd_regs
    import cfgwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_t       bus_i,
    input  logic       open_i,
    input  logic       idx_wr_i,
    input  logic       fire_i,
    input  logic [7:0] count_i,
    output wdctl_t     ctl_o,
    output logic       load_o,
    output logic [7:0] rdata_o
);
    logic [7:0] index_q;
    logic [7:0] page_q;
    wdctl_t     ctl_q;
    logic       data_wr;
    logic       wd_sel;
    logic [7:0] wd_rd;

    assign data_wr = open_i && bus_i.wr && bus_i.is_data;
    assign wd_sel  = (page_q == PAGE_WDOG);
    assign load_o  = data_wr && wd_sel && (index_q == IDX_COUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= 8'h00;
            page_q  <= 8'h00;
            ctl_q   <= '0;
        end else begin
            if (idx_wr_i) index_q <= bus_i.data;
            if (data_wr && index_q == IDX_PAGE) page_q <= bus_i.data;
            if (data_wr && wd_sel) begin
                case (index_q)
                    IDX_ENABLE: ctl_q.enable <= bus_i.data[BIT_ENABLE];
                    IDX_UNIT:   ctl_q.minutes <= bus_i.data[BIT_UNIT];
                    IDX_SRC: begin
                        ctl_q.kbd_reload   <= bus_i.data[BIT_KBD];
                        ctl_q.mouse_reload <= bus_i.data[BIT_MOUSE];
                    end
                    default: ;
                endcase
            end
            if (fire_i) ctl_q.enable <= 1'b0;
        end
    end

    always_comb begin
        case (index_q)
            IDX_ENABLE: wd_rd = place_bit(ctl_q.enable, BIT_ENABLE);
            IDX_UNIT:   wd_rd = place_bit(ctl_q.minutes, BIT_UNIT);
            IDX_COUNT:  wd_rd = count_i;
            IDX_SRC:    wd_rd = place_bit(ctl_q.kbd_reload, BIT_KBD)
                              | place_bit(ctl_q.mouse_reload, BIT_MOUSE);
            default:    wd_rd = 8'h00;
        endcase
    end

    always_comb begin
        if (!open_i)                   rdata_o = 8'hFF;
        else if (!bus_i.is_data)       rdata_o = index_q;
        else if (index_q == IDX_PAGE)  rdata_o = page_q;
        else if (!wd_sel)              rdata_o = 8'h00;
        else                           rdata_o = wd_rd;
    end

    assign ctl_o = ctl_q;

    assert_page_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(data_wr && index_q == IDX_PAGE) |=> $stable(page_q));

    assert_fire_clears_R11: assert property (@(posedge clk) disable iff (rst)
        fire_i |=> !ctl_q.enable);

    assert_sealed_ctl_R3: assert property (@(posedge clk) disable iff (rst)
        (!open_i && !fire_i) |=> $stable(ctl_q));

endmodule

// File: rtl/cfgwd_timer.sv
module cfgwd_timer
    import cfgwd_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000,
    parameter int SEC_PER_MIN   = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  wdctl_t     ctl_i,
    input  logic       load_i,
    input  logic [7:0] load_val_i,
    input  logic       kbd_i,
    input  logic       mouse_i,
    output logic [7:0] count_o,
    output logic       fire_o,
    output logic       wd_reset_o
);
    localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam int MW = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_SEC - 1);
    localparam logic [MW-1:0] MIN_LAST = MW'(SEC_PER_MIN - 1);

    logic [PW-1:0] pre_q;
    logic [MW-1:0] min_q;
    logic [7:0]    count_q;
    logic [7:0]    reload_q;
    logic          reset_q;
    logic          reload_hit, restart, sec_tick, min_tick, unit_tick;

    assign reload_hit = (kbd_i && ctl_i.kbd_reload) || (mouse_i && ctl_i.mouse_reload);
    assign restart    = load_i || reload_hit || !ctl_i.enable;
    assign sec_tick   = !restart && (pre_q == PRE_LAST);
    assign min_tick   = sec_tick && (min_q == MIN_LAST);
    assign unit_tick  = ctl_i.minutes ? min_tick : sec_tick;
    assign fire_o     = unit_tick && (count_q <= 8'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q    <= '0;
            min_q    <= '0;
            count_q  <= 8'h00;
            reload_q <= 8'h00;
            reset_q  <= 1'b0;
        end else begin
            if (restart) begin
                pre_q <= '0;
                min_q <= '0;
            end else begin
                pre_q <= sec_tick ? '0 : pre_q + 1'b1;
                if (sec_tick) min_q <= min_tick ? '0 : min_q + 1'b1;
            end
            if (load_i) begin
                count_q  <= load_val_i;
                reload_q <= load_val_i;
            end else if (reload_hit) begin
                count_q <= reload_q;
            end else if (unit_tick) begin
                count_q <= fire_o ? 8'h00 : count_q - 8'd1;
            end
            reset_q <= fire_o;
        end
    end

    assign count_o    = count_q;
    assign wd_reset_o = reset_q;

    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (rst)
        wd_reset_o |=> !wd_reset_o);

    assert_expired_zero_R11: assert property (@(posedge clk) disable iff (rst)
        wd_reset_o |-> count_q == 8'h00);

    assert_step_one_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(ctl_i.enable) && !$past(load_i) && !$past(reload_hit)
         && count_q != $past(count_q)) |-> (count_q == $past(count_q) - 8'd1 || count_q == 8'h00));

    assert_frozen_when_off_R9: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.enable && !load_i && !reload_hit) |=> $stable(count_q));

endmodule

// File: rtl/lockcfg_wdog.sv
module lockcfg_wdog
    import cfgwd_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000,
    parameter int SEC_PER_MIN   = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       port_sel,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       kbd_irq,
    input  logic       mouse_irq,
    output logic       wd_reset
);
    bus_t       bus;
    wdctl_t     ctl;
    logic       open_w, idx_wr_w, load_w, fire_w;
    logic [7:0] count_w;

    assign bus = '{wr: wr_en, is_data: port_sel, data: wdata};

    cfgwd_gate u_gate (
        .clk(clk), .rst(rst), .bus_i(bus), .open_o(open_w), .idx_wr_o(idx_wr_w)
    );

    cfgwd_regs u_regs (
        .clk(clk), .rst(rst), .bus_i(bus), .open_i(open_w), .idx_wr_i(idx_wr_w),
        .fire_i(fire_w), .count_i(count_w), .ctl_o(ctl), .load_o(load_w),
        .rdata_o(rdata)
    );

    cfgwd_timer #(.TICKS_PER_SEC(TICKS_PER_SEC), .SEC_PER_MIN(SEC_PER_MIN)) u_timer (
        .clk(clk), .rst(rst), .ctl_i(ctl), .load_i(load_w), .load_val_i(wdata),
        .kbd_i(kbd_irq), .mouse_i(mouse_irq), .count_o(count_w),
        .fire_o(fire_w), .wd_reset_o(wd_reset)
    );

endmodule

// File: tb/lockcfg_wdog_bench.sv
module lockcfg_wdog_bench;
    localparam int TPS = 4;
    localparam int SPM = 3;
    localparam logic [1:0] W = 2'd0;
    localparam logic [1:0] R = 2'd1;
    localparam logic I = 1'b0;
    localparam logic D = 1'b1;

    typedef struct packed {
        logic [1:0] op;
        logic       port;
        logic [7:0] data;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 45;
    localparam vec_t VEC [NV] = '{
        '{R, D, 8'hFF, 4'd3},  // R3 sealed data read
        '{W, D, 8'h55, 4'd3},  // R3 ignored write
        '{R, D, 8'hFF, 4'd3},
        '{W, I, 8'h87, 4'd2},  // R2 key, broken by 0x12
        '{W, I, 8'h12, 4'd2},
        '{W, I, 8'h87, 4'd2},
        '{R, I, 8'hFF, 4'd2},  // still sealed after one key
        '{W, I, 8'h87, 4'd2},
        '{R, I, 8'h00, 4'd2},  // open, index untouched
        '{W, I, 8'h07, 4'd5},  // R5 page select
        '{W, D, 8'h08, 4'd5},
        '{R, D, 8'h08, 4'd5},
        '{W, I, 8'hF5, 4'd7},  // R7 unit
        '{W, D, 8'hFF, 4'd7},
        '{R, D, 8'h08, 4'd7},
        '{W, I, 8'h30, 4'd6},  // R6 enable
        '{R, D, 8'h00, 4'd6},
        '{W, D, 8'hFF, 4'd6},
        '{R, D, 8'h01, 4'd6},
        '{W, D, 8'h00, 4'd6},
        '{R, D, 8'h00, 4'd6},
        '{W, I, 8'hF6, 4'd8},  // R8 countdown
        '{W, D, 8'h5A, 4'd8},
        '{R, D, 8'h5A, 4'd8},
        '{W, I, 8'hF7, 4'd12}, // R12 source bits
        '{W, D, 8'hFF, 4'd12},
        '{R, D, 8'hC0, 4'd12},
        '{W, I, 8'h42, 4'd13}, // R13 empty index
        '{R, D, 8'h00, 4'd13},
        '{W, I, 8'h07, 4'd5},  // R5 other page
        '{W, D, 8'h03, 4'd5},
        '{W, I, 8'hF6, 4'd5},
        '{R, D, 8'h00, 4'd5},
        '{W, D, 8'h11, 4'd5},
        '{W, I, 8'h07, 4'd5},
        '{W, D, 8'h08, 4'd5},
        '{W, I, 8'hF6, 4'd5},
        '{R, D, 8'h5A, 4'd5},
        '{W, I, 8'hAA, 4'd4},  // R4 seal
        '{R, D, 8'hFF, 4'd4},
        '{R, I, 8'hFF, 4'd4},
        '{W, I, 8'h87, 4'd2},  // R2 reopen
        '{W, I, 8'h87, 4'd2},
        '{R, I, 8'hF6, 4'd2},
        '{R, D, 8'h5A, 4'd2}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       port_sel = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       kbd_irq = 1'b0;
    logic       mouse_irq = 1'b0;
    logic       wd_reset;
    int         checks = 0;
    int         failures = 0;

    always #4 clk = ~clk;

    lockcfg_wdog #(.TICKS_PER_SEC(TPS), .SEC_PER_MIN(SPM)) u_lockcfg_wdog (
        .clk(clk), .rst(rst), .wr_en(wr_en), .port_sel(port_sel), .wdata(wdata),
        .rdata(rdata), .kbd_irq(kbd_irq), .mouse_irq(mouse_irq), .wd_reset(wd_reset)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic p, input logic [7:0] d);
        @(negedge clk);
        port_sel = p; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic p, input logic [7:0] exp, input string tag);
        @(negedge clk);
        port_sel = p;
        #1 check(tag, rdata, exp);
    endtask

    task automatic wrreg(input logic [7:0] idx, input logic [7:0] d);
        wr(I, idx); wr(D, d);
    endtask

    task automatic rdreg(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        wr(I, idx); rd(D, exp, tag);
    endtask

    task automatic pulse(input logic mouse);
        @(negedge clk);
        if (mouse) mouse_irq = 1'b1; else kbd_irq = 1'b1;
        @(negedge clk);
        kbd_irq = 1'b0; mouse_irq = 1'b0;
    endtask

    task automatic expiry_time(output int cycles);
        cycles = 0;
        while (!wd_reset && cycles < 2000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic partial_run(input logic [7:0] src);
        wrreg(8'hF5, 8'h08);
        wrreg(8'hF6, 8'd5);
        wrreg(8'h30, 8'h01);
        repeat (13) @(negedge clk);
        wrreg(8'h30, 8'h00);
        rdreg(8'hF6, 8'd4, "R9 one minute step then frozen");
        wrreg(8'hF7, src);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog timeout");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int t;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            if (VEC[k].op == W) wr(VEC[k].port, VEC[k].data);
            else rd(VEC[k].port, VEC[k].data, $sformatf("R%0d vector %0d", VEC[k].req, k));
        end

        // R1 reset state
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        #1 check("R1 reset output low", wd_reset, 0);
        rd(D, 8'hFF, "R1 sealed after reset");
        wr(I, 8'h87); wr(I, 8'h87);
        wrreg(8'h07, 8'h08);
        rdreg(8'h30, 8'h00, "R1 enable clear");
        rdreg(8'hF5, 8'h00, "R1 unit clear");
        rdreg(8'hF6, 8'h00, "R1 countdown clear");
        rdreg(8'hF7, 8'h00, "R1 sources clear");

        // R9 seconds expiry, R11 pulse
        wrreg(8'hF6, 8'd3);
        wrreg(8'h30, 8'h01);
        expiry_time(t);
        check("R9 seconds expiry clocks", t, 3 * TPS);
        @(negedge clk);
        check("R11 pulse one cycle", wd_reset, 0);
        rdreg(8'h30, 8'h00, "R11 enable cleared");
        rdreg(8'hF6, 8'h00, "R11 countdown zero");

        // R10 minutes expiry
        wrreg(8'hF5, 8'h08);
        wrreg(8'hF6, 8'd2);
        wrreg(8'h30, 8'h01);
        expiry_time(t);
        check("R10 minutes expiry clocks", t, 2 * TPS * SPM);

        // R12 keyboard reload
        partial_run(8'h00);
        pulse(1'b0); pulse(1'b1);
        rdreg(8'hF6, 8'd4, "R12 pulses ignored with sources off");
        wrreg(8'hF7, 8'h40);
        pulse(1'b0);
        rdreg(8'hF6, 8'd5, "R12 keyboard reload");

        // R12 mouse reload
        partial_run(8'h80);
        pulse(1'b0);
        rdreg(8'hF6, 8'd4, "R12 keyboard ignored when bit 6 clear");
        pulse(1'b1);
        rdreg(8'hF6, 8'd5, "R12 mouse reload");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule